// File: doc/BRIEF.md
# Low-Order Tributary Overhead Builder

This block produces the transmit-side overhead for a single low-order tributary channel. The channel is either a 1.5 Mbit/s or a 2 Mbit/s virtual tributary. The block sits in a byte stream that already carries the channel payload. An external position counter marks each byte with a slot code. The block passes payload bytes through unchanged. In the two pointer slots it writes a fixed pointer pair, chosen by the tributary size. In the path-overhead slot it builds the V5 byte.

V5 holds several fields. The first is a two-bit interleaved parity, computed over every byte sent since the previous V5. The remaining fields are a remote error indication, a remote failure bit, a three-bit signal label and a remote defect bit. Each of these comes straight from a control input. A troubleshooting control inverts both parity bits on every superframe while it is held high. A downstream receiver then counts a parity error in every superframe.

The output is registered, so every accepted byte appears one clock later. Bytes with the valid input low are not accepted, and they add nothing to the parity.

Top module: `vt_oh_gen`

## Requirements
- R1: A valid byte in slot code 0 (payload) appears unchanged on `tx_byte` with `tx_valid` high, one clock after it is accepted.
- R2: A valid byte in slot code 1 is replaced by the first pointer byte and one in slot code 2 by the second. With `vt2_mode` high these are 0x68 and 0x69. With `vt2_mode` low they are 0x6C and 0x4E.
- R3: A valid byte in slot code 3 is replaced by V5. Its layout, from bit 7 down, is parity bit A, parity bit B, REI, RFI, label bits 2..0, RDI.
- R4: Parity bit A is even parity over bits 7, 5, 3 and 1 of every output byte from the previous V5 (inclusive) up to the current V5 (exclusive). Parity bit B covers bits 6, 4, 2 and 0 in the same way. Accumulation restarts at every V5.
- R5: The first V5 after reset carries parity bits 00 when error insertion is off.
- R6: While `bip_err_ins` is 1, every V5 carries both parity bits inverted. The inverted V5, as transmitted, starts the next accumulation. Once the control returns to 0, the parity is correct again.
- R7: The REI, RFI, label and RDI fields of V5 equal `rei_ind`, `rfi_force`, `sig_label` and `rdi_ind` as sampled in the V5 slot.
- R8: A cycle with `in_valid` low gives `tx_valid` low one clock later. `tx_byte` holds its value, and that byte's contents do not enter the parity.
- R9: During reset, `tx_valid` and `tx_byte` are 0 and the parity accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` and `slot` is accepted this cycle |
| slot | input | 2 | Position code: 0 payload, 1 pointer byte 1, 2 pointer byte 2, 3 V5 |
| in_byte | input | 8 | Incoming payload byte |
| vt2_mode | input | 1 | 1 selects the 2 Mbit/s tributary pointer values, 0 the 1.5 Mbit/s values |
| bip_err_ins | input | 1 | Invert both parity bits of V5 |
| rei_ind | input | 1 | REI value for V5 |
| rfi_force | input | 1 | RFI value for V5 |
| sig_label | input | 3 | Signal label for V5 |
| rdi_ind | input | 1 | RDI value for V5 |
| tx_valid | output | 1 | `tx_byte` holds a new byte |
| tx_byte | output | 8 | Outgoing byte |

## Verification
The bench starts by checking the first V5 after reset. A design whose accumulator came out of reset dirty would send a parity other than 00 there. The bench then runs superframes in which the payload contains only odd-position ones, only even-position ones, all ones, and ramps. A design that swapped the bit interleaving, or that left the V5 or pointer bytes out of the parity, would produce wrong parity bits in the following V5. Two superframes run with error insertion on, followed by a clean one. A design that folded the uncorrupted parity into the next accumulation, or that held the inversion on, would be caught in the frame after the control drops. Idle cycles carry junk on the data input. These expose any design that lets discarded bytes reach the parity or the output.

// File: rtl/vt_oh_gen.sv
module vt_oh_gen #(
  parameter int          DW      = 8,
  parameter logic [7:0]  V1_WIDE = 8'h68,
  parameter logic [7:0]  V2_WIDE = 8'h69,
  parameter logic [7:0]  V1_NARR = 8'h6C,
  parameter logic [7:0]  V2_NARR = 8'h4E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    slot,
  input  logic [DW-1:0] in_byte,
  input  logic          vt2_mode,
  input  logic          bip_err_ins,
  input  logic          rei_ind,
  input  logic          rfi_force,
  input  logic [2:0]    sig_label,
  input  logic          rdi_ind,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte
);

  localparam logic [1:0] SL_DATA = 2'd0;
  localparam logic [1:0] SL_PTR1 = 2'd1;
  localparam logic [1:0] SL_PTR2 = 2'd2;
  localparam logic [1:0] SL_V5   = 2'd3;
  localparam logic [DW-1:0] ODD_MASK = {(DW/2){2'b10}};

  logic [1:0]    par_acc;
  logic [DW-1:0] v5_byte;
  logic [DW-1:0] nxt_byte;
  logic [1:0]    nxt_fold;

  assign v5_byte  = {par_acc ^ {2{bip_err_ins}}, rei_ind, rfi_force, sig_label, rdi_ind};
  assign nxt_fold = {^(nxt_byte & ODD_MASK), ^(nxt_byte & ~ODD_MASK)};

  always_comb begin
    case (slot)
      SL_PTR1: nxt_byte = vt2_mode ? V1_WIDE : V1_NARR;
      SL_PTR2: nxt_byte = vt2_mode ? V2_WIDE : V2_NARR;
      SL_V5:   nxt_byte = v5_byte;
      default: nxt_byte = in_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      par_acc  <= 2'b00;
    end else if (in_valid) begin
      tx_valid <= 1'b1;
      tx_byte  <= nxt_byte;
      par_acc  <= (slot == SL_V5) ? nxt_fold : (par_acc ^ nxt_fold);
    end else begin
      tx_valid <= 1'b0;
    end
  end

  assert_payload_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && slot == SL_DATA) |=> (tx_valid && tx_byte == $past(in_byte)));

  assert_ptr_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && slot == SL_PTR2 && !vt2_mode) |=> (tx_byte == V2_NARR));

  assert_v5_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && slot == SL_V5) |=>
      (tx_byte[5] == $past(rei_ind) && tx_byte[4] == $past(rfi_force) &&
       tx_byte[3:1] == $past(sig_label) && tx_byte[0] == $past(rdi_ind)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!tx_valid && $stable(tx_byte)));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> tx_valid);

endmodule

// File: tb/sim_vt_oh_gen.sv
module sim_vt_oh_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] slot = 2'd0;
  logic [7:0] in_byte = 8'h00;
  logic vt2_mode = 1'b1;
  logic bip_err_ins = 1'b0;
  logic rei_ind = 1'b0;
  logic rfi_force = 1'b0;
  logic [2:0] sig_label = 3'b010;
  logic rdi_ind = 1'b0;
  logic tx_valid;
  logic [7:0] tx_byte;

  int n_tests = 0;
  int n_fail  = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] m_acc = 2'b00;
  logic [7:0] m_last = 8'h00;

  always #2.5 clk = ~clk;

  vt_oh_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .slot(slot), .in_byte(in_byte),
    .vt2_mode(vt2_mode), .bip_err_ins(bip_err_ins), .rei_ind(rei_ind),
    .rfi_force(rfi_force), .sig_label(sig_label), .rdi_ind(rdi_ind),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  function automatic logic [1:0] fold(input logic [7:0] b);
    return {b[7]^b[5]^b[3]^b[1], b[6]^b[4]^b[2]^b[0]};
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: valid/byte actual %0b/%h expected %0b/%h", tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // Driver: applies one cycle and pushes the expected output of that cycle.
  task automatic send(input logic v, input logic [1:0] s, input logic [7:0] d, input string tag);
    logic [7:0] o;
    @(negedge clk);
    in_valid = v; slot = s; in_byte = d;
    if (v) begin
      case (s)
        2'd1: o = vt2_mode ? 8'h68 : 8'h6C;
        2'd2: o = vt2_mode ? 8'h69 : 8'h4E;
        2'd3: o = {m_acc ^ {2{bip_err_ins}}, rei_ind, rfi_force, sig_label, rdi_ind};
        default: o = d;
      endcase
      m_acc  = (s == 2'd3) ? fold(o) : (m_acc ^ fold(o));
      m_last = o;
    end else begin
      o = m_last;
    end
    exp_q.push_back({v, o});
    tag_q.push_back(tag);
  endtask

  // One superframe, pointer bytes placed between payload runs.
  task automatic frame(input int kind, input string v5tag);
    send(1'b1, 2'd3, 8'h00, v5tag);
    for (int i = 0; i < 10; i++) begin
      case (kind)
        0: send(1'b1, 2'd0, 8'hAA, "R1");
        1: send(1'b1, 2'd0, 8'h55, "R1");
        2: send(1'b1, 2'd0, 8'hFF, "R1");
        default: send(1'b1, 2'd0, 8'(i * 37 + 5), "R1");
      endcase
    end
    send(1'b1, 2'd1, 8'h00, "R2");
    send(1'b1, 2'd2, 8'h00, "R2");
    for (int i = 0; i < 5; i++) send(1'b1, 2'd0, 8'(i * 91 + kind), "R1");
  endtask

  // Monitor: compares outputs 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {tx_valid, tx_byte}, e);
      end
    end
  end

  initial begin
    fork
      begin : wdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin : main
        repeat (3) @(posedge clk);
        #1 check("R9", {tx_valid, tx_byte}, 9'h000);
        @(negedge clk); rst_n = 1'b1;
        // R5: first V5 after reset carries parity 00
        send(1'b1, 2'd3, 8'h00, "R5");
        for (int i = 0; i < 4; i++) send(1'b1, 2'd0, 8'hAA, "R1");
        // R4: several payload patterns
        frame(0, "R4"); frame(1, "R4"); frame(2, "R4"); frame(3, "R4");
        // R6: inversion for two frames, then clean
        bip_err_ins = 1'b1;
        frame(3, "R6"); frame(0, "R6");
        bip_err_ins = 1'b0;
        frame(1, "R6"); frame(2, "R4");
        // R7 and R3: field values in V5
        rei_ind = 1'b1; rfi_force = 1'b1; sig_label = 3'b101; rdi_ind = 1'b1;
        frame(3, "R7");
        rei_ind = 1'b0; rfi_force = 1'b1; sig_label = 3'b110; rdi_ind = 1'b0;
        frame(0, "R3");
        // R8: idle cycles with junk data, parity unaffected
        send(1'b1, 2'd3, 8'h00, "R4");
        send(1'b1, 2'd0, 8'h81, "R1");
        for (int i = 0; i < 4; i++) send(1'b0, 2'd0, 8'hFF, "R8");
        send(1'b0, 2'd3, 8'h13, "R8");
        send(1'b1, 2'd0, 8'h42, "R1");
        send(1'b1, 2'd3, 8'h00, "R8");
        // R2: narrow tributary pointer values
        vt2_mode = 1'b0;
        frame(2, "R4"); frame(3, "R4");
        send(1'b0, 2'd0, 8'h00, "R8");
        send(1'b0, 2'd0, 8'h00, "R8");
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        disable wdog;
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule